// File: doc/BRIEF.md
# Ultra DMA Write-Burst Receiver

This block is the device-side receiver for a host-to-device Ultra DMA write burst on a 16-bit parallel bus. The host toggles a data strobe, and every transition of that strobe carries one 16-bit word. The block runs on a fast system clock that oversamples the strobe. The strobe, the data bus and the host control lines pass through two-flop synchronizers. A strobe transition is detected by comparing successive synchronized samples, and the word sampled alongside it is presented for one cycle on a valid/data output toward a downstream buffer.

A state machine follows the burst. The phases are: `IDLE` (phase 0), `ARMED` (phase 1, waiting for the host to drop STOP), `XFER` (phase 2, moving words), `HOLD` (phase 3, the host has paused by holding the strobe level) and `TERM` (phase 4, the host ended the burst). The transitions are:
- IDLE→ARMED when the device requests a burst and the host write strobe is negated.
- ARMED→IDLE when the request is withdrawn.
- ARMED→XFER once STOP is low.
- XFER→HOLD after `PAUSE_CYC` clocks without a strobe transition.
- HOLD→XFER on the next transition, which also captures its word.
- XFER→TERM or HOLD→TERM when STOP rises.
- TERM→IDLE on the following clock.

The block drives a device-ready flow-control output from the room left in the downstream buffer. It keeps a count of the words received in the current burst and gives a one-cycle done pulse when the burst ends.

Top module: `udma_out_rx`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `phase` is 0 (IDLE) and `word_cnt`, `dev_ready`, `word_valid` and `done` are all 0.
- R2: In phase 2 (XFER), each rising and each falling transition of `hstrobe` produces exactly one `word_valid` pulse of one cycle. `word_data` equals the `hdata` value held at that transition. The pulse appears on the third rising clock edge after the input change.
- R3: While `host_wr_n` is low (asserted), the block stays in phase 0 even when `burst_req` is high. It produces no words and keeps `dev_ready` low.
- R4: In phase 1 (ARMED, STOP still high), strobe transitions produce no words, and the phase stays 1 until STOP goes low.
- R5: After `PAUSE_CYC` clocks in XFER with no strobe transition, the phase becomes 3 (HOLD) and no words are produced. The next transition returns the phase to 2 and delivers its word.
- R6: STOP rising in phase 2 or 3 moves the phase to 4 (TERM) for exactly one cycle, with `done` high in that cycle only. The phase then returns to 0. Strobe transitions after that produce no words.
- R7: `dev_ready` is high only in phases 1 to 3 and only while `buf_room` is at least `READY_MIN` (2). It follows a change of `buf_room` at the next clock edge.
- R8: `word_cnt` rises by one with each delivered word. It is cleared to 0 on the IDLE→ARMED transition and keeps its value after termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock oversampling the host lines |
| rst_n | input | 1 | Active-low reset |
| burst_req | input | 1 | Device wants a write burst (device-side request) |
| host_wr_n | input | 1 | Host write strobe, active low; must be high before a burst |
| host_stop | input | 1 | Host STOP line, active high |
| hstrobe | input | 1 | Host data strobe; every transition carries a word |
| hdata | input | DW (16) | Host data bus |
| buf_room | input | ROOM_W (8) | Free word slots in the downstream buffer |
| word_valid | output | 1 | One-cycle pulse: `word_data` holds a received word |
| word_data | output | DW (16) | Received word |
| word_cnt | output | CNT_W (16) | Words received in the current burst |
| dev_ready | output | 1 | Device ready for more data (flow control) |
| done | output | 1 | One-cycle pulse when the burst terminates |
| phase | output | 3 | Current phase: 0 IDLE, 1 ARMED, 2 XFER, 3 HOLD, 4 TERM |

## Verification
The strobe is toggled in four situations:
- With the host write strobe asserted, which shows whether the idle guard holds.
- With STOP still high, which shows whether the armed phase ignores transitions.
- In a running burst that alternates rising and falling transitions with distinct data, which shows both-edge capture, data alignment and counting.
- After a long quiet gap, which shows that pause entry and resumption lose or invent no word.

STOP is also raised mid-burst and then followed by extra transitions, which separates a clean termination from one that keeps capturing. The buffer room is stepped across the threshold to confirm that flow control follows it.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ARMED = 3'd1,
        PH_XFER  = 3'd2,
        PH_HOLD  = 3'd3,
        PH_TERM  = 3'd4
    } phase_t;

    function automatic logic phase_active(input phase_t p);
        return (p == PH_ARMED) || (p == PH_XFER) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/udma_edge_cap.sv
module udma_edge_cap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_s,
    input  logic [DW-1:0] data_s,
    output logic          strb_edge,
    output logic [DW-1:0] edge_data
);
    logic strb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_prev <= 1'b0;
        else        strb_prev <= strb_s;
    end

    assign strb_edge = strb_s ^ strb_prev;
    assign edge_data = data_s;
endmodule

// File: rtl/udma_rx_fsm.sv
module udma_rx_fsm
    import udma_rx_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CNT_W     = 16,
    parameter int ROOM_W    = 8,
    parameter int READY_MIN = 2,
    parameter int PAUSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic              wr_neg_s,
    input  logic              stop_s,
    input  logic              strb_edge,
    input  logic [DW-1:0]     edge_data,
    input  logic [ROOM_W-1:0] buf_room,
    output phase_t            st,
    output logic              word_valid,
    output logic [DW-1:0]     word_data,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              dev_ready,
    output logic              done
);
    localparam int QW = $clog2(PAUSE_CYC + 1);
    localparam logic [QW-1:0]     QUIET_LAST = QW'(PAUSE_CYC - 1);
    localparam logic [ROOM_W-1:0] ROOM_MIN   = ROOM_W'(READY_MIN);

    phase_t        nxt;
    logic          take;
    logic [QW-1:0] quiet_cnt;

    always_comb begin
        nxt  = st;
        take = 1'b0;
        unique case (st)
            PH_IDLE: begin
                if (burst_req && wr_neg_s) nxt = PH_ARMED;
            end
            PH_ARMED: begin
                if (!burst_req)   nxt = PH_IDLE;
                else if (!stop_s) nxt = PH_XFER;
            end
            PH_XFER: begin
                if (stop_s)                       nxt = PH_TERM;
                else if (strb_edge)               take = 1'b1;
                else if (quiet_cnt == QUIET_LAST) nxt = PH_HOLD;
            end
            PH_HOLD: begin
                if (stop_s) nxt = PH_TERM;
                else if (strb_edge) begin
                    take = 1'b1;
                    nxt  = PH_XFER;
                end
            end
            PH_TERM: nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // state register and pause timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= PH_IDLE;
            quiet_cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt != PH_XFER || take || st != PH_XFER) quiet_cnt <= '0;
            else                                         quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_cnt   <= '0;
            dev_ready  <= 1'b0;
            done       <= 1'b0;
        end else begin
            word_valid <= take;
            if (take) word_data <= edge_data;
            if (st == PH_IDLE && nxt == PH_ARMED) word_cnt <= '0;
            else if (take)                        word_cnt <= word_cnt + 1'b1;
            dev_ready <= phase_active(nxt) && (buf_room >= ROOM_MIN);
            done      <= (nxt == PH_TERM);
        end
    end
endmodule

// File: rtl/udma_out_rx.sv
module udma_out_rx
    import udma_rx_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CNT_W     = 16,
    parameter int ROOM_W    = 8,
    parameter int READY_MIN = 2,
    parameter int PAUSE_CYC = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic              host_wr_n,
    input  logic              host_stop,
    input  logic              hstrobe,
    input  logic [DW-1:0]     hdata,
    input  logic [ROOM_W-1:0] buf_room,
    output logic              word_valid,
    output logic [DW-1:0]     word_data,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              dev_ready,
    output logic              done,
    output logic [2:0]        phase
);
    localparam int LW = DW + 3;

    logic [LW-1:0] raw_bus, sync_bus;
    logic          strb_edge;
    logic [DW-1:0] edge_data;
    phase_t        st;

    assign raw_bus = {hdata, hstrobe, host_stop, host_wr_n};

    udma_sync #(.W(LW), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    udma_edge_cap #(.DW(DW)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_s    (sync_bus[2]),
        .data_s    (sync_bus[LW-1:3]),
        .strb_edge (strb_edge),
        .edge_data (edge_data)
    );

    udma_rx_fsm #(
        .DW        (DW),
        .CNT_W     (CNT_W),
        .ROOM_W    (ROOM_W),
        .READY_MIN (READY_MIN),
        .PAUSE_CYC (PAUSE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_req  (burst_req),
        .wr_neg_s   (sync_bus[0]),
        .stop_s     (sync_bus[1]),
        .strb_edge  (strb_edge),
        .edge_data  (edge_data),
        .buf_room   (buf_room),
        .st         (st),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_cnt   (word_cnt),
        .dev_ready  (dev_ready),
        .done       (done)
    );

    assign phase = st;
endmodule

// File: rtl/udma_out_rx_chk.sv
module udma_out_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic [CNT_W-1:0] word_cnt,
    input logic             dev_ready,
    input logic             done,
    input logic [2:0]       phase
);
    p_phase_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4);

    p_valid_in_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> phase == 3'd2);

    p_hold_from_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |-> ($past(phase) == 3'd2 || $past(phase) == 3'd3));

    p_done_in_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> phase == 3'd4);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && phase == 3'd0));

    p_ready_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> (phase == 3'd1 || phase == 3'd2 || phase == 3'd3));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_cnt == CNT_W'($past(word_cnt) + 1'b1));
endmodule

bind udma_out_rx udma_out_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_cnt   (word_cnt),
    .dev_ready  (dev_ready),
    .done       (done),
    .phase      (phase)
);

// File: tb/sim_udma_out_rx.sv
`timescale 1ns/1ps
module sim_udma_out_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_req = 1'b0;
    logic        host_wr_n = 1'b0;
    logic        host_stop = 1'b1;
    logic        hstrobe = 1'b0;
    logic [15:0] hdata = '0;
    logic [7:0]  buf_room = 8'd16;
    logic        word_valid;
    logic [15:0] word_data;
    logic [15:0] word_cnt;
    logic        dev_ready;
    logic        done;
    logic [2:0]  phase;

    int nchk = 0;
    int nfail = 0;
    int ngot = 0;
    logic [15:0] got [0:63];
    bit finished = 0;

    always #2.5 clk = ~clk;

    udma_out_rx u0 (
        .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .host_wr_n(host_wr_n),
        .host_stop(host_stop), .hstrobe(hstrobe), .hdata(hdata), .buf_room(buf_room),
        .word_valid(word_valid), .word_data(word_data), .word_cnt(word_cnt),
        .dev_ready(dev_ready), .done(done), .phase(phase)
    );

    always @(negedge clk) begin
        if (rst_n && word_valid && ngot < 64) begin
            got[ngot] = word_data;
            ngot++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle(input logic [15:0] v);
        @(negedge clk);
        hdata   = v;
        hstrobe = ~hstrobe;
        wait_n(1);
    endtask

    task automatic t_reset;
        wait_n(3);
        chk("R1 phase in reset", phase, 0);
        chk("R1 ready in reset", dev_ready, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 phase", phase, 0);
        chk("R1 count", word_cnt, 0);
        chk("R1 valid/done/ready", {word_valid, done, dev_ready}, 0);
    endtask

    task automatic t_wr_asserted;   // R3
        burst_req = 1'b1; host_wr_n = 1'b0; host_stop = 1'b0;
        for (int i = 0; i < 4; i++) toggle(16'h0100 + 16'(i));
        wait_n(4);
        chk("R3 phase stays idle", phase, 0);
        chk("R3 no words", ngot, 0);
        chk("R3 ready low", dev_ready, 0);
    endtask

    task automatic t_stop_at_start; // R4
        @(negedge clk);
        host_stop = 1'b1; host_wr_n = 1'b1;
        wait_n(5);
        chk("R4 armed", phase, 1);
        chk("R7 ready in armed", dev_ready, 1);
        for (int i = 0; i < 4; i++) toggle(16'h0200 + 16'(i));
        wait_n(4);
        chk("R4 no words while stop high", ngot, 0);
        chk("R4 still armed", phase, 1);
    endtask

    task automatic t_latency;       // R2
        @(negedge clk) host_stop = 1'b0;
        wait_n(5);
        chk("R2 xfer entered", phase, 2);
        @(negedge clk);
        hdata = 16'h1234; hstrobe = ~hstrobe;
        wait_n(2);
        chk("R2 not yet valid", word_valid, 0);
        wait_n(1);
        chk("R2 valid on third edge", word_valid, 1);
        chk("R2 latency data", word_data, 16'h1234);
        wait_n(1);
        chk("R2 single pulse", word_valid, 0);
        chk("R2 one word", ngot, 1);
    endtask

    task automatic t_burst;         // R2, R8
        for (int i = 0; i < 6; i++) toggle(16'hA000 + 16'(i * 16'h111));
        wait_n(4);
        chk("R2 word count both edges", ngot, 7);
        for (int i = 0; i < 6; i++)
            chk("R2 word value", got[i+1], 16'hA000 + 16'(i * 16'h111));
        chk("R8 word_cnt", word_cnt, 7);
    endtask

    task automatic t_pause;         // R5
        wait_n(16);
        chk("R5 paused", phase, 3);
        chk("R5 no words in pause", ngot, 7);
        toggle(16'hBEEF);
        wait_n(3);
        chk("R5 resume word", ngot, 8);
        chk("R5 resume value", got[7], 16'hBEEF);
        chk("R5 back to xfer", phase, 2);
    endtask

    task automatic t_ready;         // R7
        @(negedge clk) buf_room = 8'd1;
        @(negedge clk);
        chk("R7 ready drops at room 1", dev_ready, 0);
        buf_room = 8'd2;
        @(negedge clk);
        chk("R7 ready at room 2", dev_ready, 1);
        buf_room = 8'd16;
    endtask

    task automatic t_stop_end;      // R6
        int ndone = 0;
        logic [2:0] ph_at_done = 3'd7;
        @(negedge clk);
        host_stop = 1'b1; burst_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) begin ndone++; ph_at_done = phase; end
        end
        chk("R6 one done pulse", ndone, 1);
        chk("R6 term phase with done", ph_at_done, 4);
        chk("R6 idle after term", phase, 0);
        chk("R7 ready low in idle", dev_ready, 0);
        toggle(16'h5555); toggle(16'h6666);
        wait_n(4);
        chk("R6 no words after stop", ngot, 8);
        chk("R8 count held after term", word_cnt, 8);
    endtask

    task automatic t_new_burst;     // R8
        @(negedge clk) burst_req = 1'b1;
        wait_n(4);
        chk("R8 armed again", phase, 1);
        chk("R8 count cleared", word_cnt, 0);
        @(negedge clk) host_stop = 1'b0;
        wait_n(4);
        toggle(16'hC001); toggle(16'hC002);
        wait_n(4);
        chk("R8 count new burst", word_cnt, 2);
        chk("R2 new burst words", ngot, 10);
        chk("R2 new burst data", got[9], 16'hC002);
    endtask

    initial begin
        t_reset();
        t_wr_asserted();
        t_stop_at_start();
        t_latency();
        t_burst();
        t_pause();
        t_ready();
        t_stop_end();
        t_new_burst();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule